// File: doc/BRIEF.md
# Clock-Domain Event Pulse Crosser

This block moves single-cycle event strobes from one clock domain into a second, unrelated one. Every strobe accepted on the source side comes out as exactly one single-cycle strobe on the destination clock. Strobes may arrive on every source cycle. In the default mode, the source keeps a running event count and sends it across in Gray code. Only one bit of the crossing bus changes per source cycle, so a two-flop synchronizer on the destination side always resolves to a valid count. The destination keeps its own count of strobes already emitted. While that count trails the received count, it emits one strobe per destination clock.

The destination's emitted count returns to the source through the same kind of Gray-coded synchronizer. The source uses it to cap how far it may run ahead. If a strobe arrives while the source already has the maximum number of events outstanding, the source refuses it and raises a sticky overflow flag. A parameter selects a lighter toggle mode for sparse traffic. In that mode, each strobe flips a single register bit, and an edge detector on the destination side turns each synchronized flip into a strobe.

Top module: `evt_xing`

## Requirements
- R1: While its reset is high and in the first cycle after it, each domain holds its output low: `dst_evt` in the destination domain, `src_ovf` in the source domain. All event counters clear to zero.
- R2: In counter mode, with at most 7 events outstanding, the number of destination strobes equals the number of source strobes. This holds for any spacing, including a strobe on every source cycle.
- R3: Each event produces one destination cycle with `dst_evt` high. At most one event leaves per destination cycle, and back-to-back events give consecutive high cycles.
- R4: An isolated source strobe appears on `dst_evt` between 2 and 5 destination clock edges after the source edge that sampled it.
- R5: The count bus crossing into the destination domain is Gray coded and changes in at most one bit per source clock.
- R6: In counter mode, with a 4-bit count, a strobe that arrives while the source sees 7 events not yet acknowledged is refused and never emerges. The refusal sets `src_ovf` in the following source cycle. `src_ovf` then stays high until `src_rst`.
- R7: In toggle mode, strobes spaced at least 3 source cycles apart each produce exactly one single-cycle destination strobe.
- R8: In toggle mode, `src_ovf` stays low regardless of traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| src_evt | input | 1 | Event strobe, one event per high cycle |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Synchronous active-high reset, destination domain |
| dst_evt | output | 1 | Event strobe in the destination domain |
| src_ovf | output | 1 | Sticky flag: a source event was refused |

## Verification
The bench sweeps burst length against inter-strobe gap, down to a strobe on every source cycle, with slightly mismatched clock periods. A design that let several count bits change at once, or that merged strobes, would emit fewer strobes than were sent. To force overflow, the bench freezes the destination clock and sends ten strobes. A design that failed to throttle would wrap its 4-bit count and lose or invent events once the clock resumes; exactly seven must emerge, and the flag must stay set until the source reset. Toggle mode is swept only at legal spacing, where a broken edge detector would give double-wide or missing strobes. Isolated strobes are timed to catch extra or missing pipeline stages.

// File: rtl/evt_xing_pkg.sv
package evt_xing_pkg;

    // crossing scheme selected by the top-level parameter
    typedef enum logic {
        XM_GRAY   = 1'b0,
        XM_TOGGLE = 1'b1
    } xing_mode_e;

    // widest count the helper functions accept
    localparam int unsigned MAXW = 16;

    // per-cycle decision made by the source counter
    typedef struct packed {
        logic fire;   // strobe accepted, count advances
        logic drop;   // strobe refused, window full
    } src_dec_t;

    // bit i of the binary value equals the XOR of Gray bits i and above
    function automatic logic gray_bit_to_bin(input logic [MAXW-1:0] g, input int unsigned i);
        return ^(g >> i);
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/evt_src_gray.sv
module evt_src_gray
    import evt_xing_pkg::*;
#(
    parameter int unsigned CW     = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_i,
    input  logic [CW-1:0] ack_gray_i,   // destination emitted count, other domain
    output logic [CW-1:0] gray_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] MAX_AHEAD = CW'((1 << (CW - 1)) - 1);

    logic [CW-1:0] bin_q, gray_q, ack_sync, ack_bin, ahead, bin_nx;
    logic          ovf_q;
    src_dec_t      dec;

    evt_sync #(.W(CW), .STAGES(STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_gray_i),
        .q   (ack_sync)
    );

    always_comb begin
        for (int unsigned i = 0; i < CW; i++)
            ack_bin[i] = gray_bit_to_bin(MAXW'(ack_sync), i);
    end

    assign ahead    = bin_q - ack_bin;
    assign dec.fire = evt_i && (ahead < MAX_AHEAD);
    assign dec.drop = evt_i && (ahead >= MAX_AHEAD);
    assign bin_nx   = bin_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (dec.fire) begin
                bin_q  <= bin_nx;
                gray_q <= bin_nx ^ (bin_nx >> 1);
            end
            if (dec.drop) ovf_q <= 1'b1;
        end
    end

    assign gray_o = gray_q;
    assign ovf_o  = ovf_q;

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ahead <= MAX_AHEAD); // R6
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt_i && ahead == MAX_AHEAD) |=> (ovf_q && $stable(bin_q))); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R6
endmodule

// File: rtl/evt_dst_gray.sv
module evt_dst_gray
    import evt_xing_pkg::*;
#(
    parameter int unsigned CW     = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] src_gray_i,   // source count, other domain
    output logic          evt_o,
    output logic [CW-1:0] ack_gray_o
);
    localparam logic [CW-1:0] MAX_AHEAD = CW'((1 << (CW - 1)) - 1);

    logic [CW-1:0] tgt_sync, tgt_bin, cnt_q, cnt_nx, ack_q;
    logic          evt_q, behind;

    evt_sync #(.W(CW), .STAGES(STAGES)) u_fwd_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_gray_i),
        .q   (tgt_sync)
    );

    always_comb begin
        for (int unsigned i = 0; i < CW; i++)
            tgt_bin[i] = gray_bit_to_bin(MAXW'(tgt_sync), i);
    end

    assign behind = (tgt_bin != cnt_q);
    assign cnt_nx = cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ack_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= behind;
            if (behind) begin
                cnt_q <= cnt_nx;
                ack_q <= cnt_nx ^ (cnt_nx >> 1);
            end
        end
    end

    assign evt_o      = evt_q;
    assign ack_gray_o = ack_q;

    AST_CATCH_UP: assert property (@(posedge clk) disable iff (rst)
        (tgt_bin != cnt_q) |=> evt_q); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tgt_bin == cnt_q) |=> !evt_q); // R3
    AST_NO_RUNAWAY: assert property (@(posedge clk) disable iff (rst)
        (tgt_bin - cnt_q) <= MAX_AHEAD); // R2
    AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(ack_q ^ $past(ack_q)) <= 1); // R5
endmodule

// File: rtl/evt_toggle.sv
module evt_toggle #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_evt,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_evt
);
    logic tog_q, tog_sync, last_q, evt_q;

    always_ff @(posedge src_clk) begin
        if (src_rst)      tog_q <= 1'b0;
        else if (src_evt) tog_q <= ~tog_q;
    end

    evt_sync #(.W(1), .STAGES(STAGES)) u_tog_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tog_q),
        .q   (tog_sync)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            last_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            last_q <= tog_sync;
            evt_q  <= tog_sync ^ last_q;
        end
    end

    assign dst_evt = evt_q;

    AST_TGL_SPACING: assert property (@(posedge src_clk) disable iff (src_rst)
        src_evt |=> !src_evt); // R7
    AST_TGL_SINGLE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        evt_q |=> !evt_q); // R7
endmodule

// File: rtl/evt_xing.sv
module evt_xing
    import evt_xing_pkg::*;
#(
    parameter xing_mode_e  MODE   = XM_GRAY,
    parameter int unsigned CW     = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_evt,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_evt,
    output logic src_ovf
);
    generate
        if (MODE == XM_GRAY) begin : g_gray
            logic [CW-1:0] fwd_gray, ack_gray;

            evt_src_gray #(.CW(CW), .STAGES(STAGES)) u_src (
                .clk        (src_clk),
                .rst        (src_rst),
                .evt_i      (src_evt),
                .ack_gray_i (ack_gray),
                .gray_o     (fwd_gray),
                .ovf_o      (src_ovf)
            );

            evt_dst_gray #(.CW(CW), .STAGES(STAGES)) u_dst (
                .clk        (dst_clk),
                .rst        (dst_rst),
                .src_gray_i (fwd_gray),
                .evt_o      (dst_evt),
                .ack_gray_o (ack_gray)
            );
        end else begin : g_toggle
            evt_toggle #(.STAGES(STAGES)) u_tgl (
                .src_clk (src_clk),
                .src_rst (src_rst),
                .src_evt (src_evt),
                .dst_clk (dst_clk),
                .dst_rst (dst_rst),
                .dst_evt (dst_evt)
            );
            assign src_ovf = 1'b0;

            AST_TGL_NO_OVF: assert property (@(posedge src_clk) !src_ovf); // R8
        end
    endgenerate

    AST_DST_RST_QUIET: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $past(dst_rst) |-> !dst_evt); // R1
    AST_SRC_RST_QUIET: assert property (@(posedge src_clk) disable iff (src_rst)
        $past(src_rst) |-> !src_ovf); // R1
endmodule

// File: tb/sim_evt_xing.sv
module sim_evt_xing;
    import evt_xing_pkg::*;

    logic src_clk = 1'b0, dst_clk = 1'b0, dclk_en = 1'b1;
    logic src_rst = 1'b1, dst_rst = 1'b1;
    logic g_in = 1'b0, t_in = 1'b0;
    logic g_out, g_ovf, t_out, t_ovf;

    int n_cmp = 0, n_bad = 0;
    int g_sent = 0, g_seen = 0, t_sent = 0, t_seen = 0, dedges = 0;
    bit done = 1'b0;

    evt_xing #(.MODE(XM_GRAY), .CW(4), .STAGES(2)) u0 (
        .src_clk (src_clk), .src_rst (src_rst), .src_evt (g_in),
        .dst_clk (dst_clk), .dst_rst (dst_rst), .dst_evt (g_out),
        .src_ovf (g_ovf)
    );

    evt_xing #(.MODE(XM_TOGGLE), .CW(4), .STAGES(2)) u1 (
        .src_clk (src_clk), .src_rst (src_rst), .src_evt (t_in),
        .dst_clk (dst_clk), .dst_rst (dst_rst), .dst_evt (t_out),
        .src_ovf (t_ovf)
    );

    // 50 MHz source, slightly slower destination that can be frozen
    always #10 src_clk = ~src_clk;
    initial begin
        #7;
        forever begin
            #11;
            if (dclk_en) dst_clk = ~dst_clk;
        end
    end

    always @(posedge dst_clk) dedges++;
    always @(negedge dst_clk) begin
        if (g_out) g_seen++;
        if (t_out) t_seen++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic joint_reset();
        @(negedge src_clk);
        src_rst = 1'b1;
        dst_rst = 1'b1;
        repeat (6) @(negedge src_clk);
        src_rst = 1'b0;
        @(negedge dst_clk);
        dst_rst = 1'b0;
        repeat (4) @(negedge src_clk);
    endtask

    task automatic drain();
        repeat (30) @(negedge dst_clk);
    endtask

    // len strobes, gap idle source cycles between them
    task automatic g_burst(input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            @(negedge src_clk) g_in = 1'b1;
            g_sent++;
            for (int k = 0; k < gap; k++) @(negedge src_clk) g_in = 1'b0;
        end
        @(negedge src_clk) g_in = 1'b0;
    endtask

    task automatic t_burst(input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            @(negedge src_clk) t_in = 1'b1;
            t_sent++;
            for (int k = 0; k < gap; k++) @(negedge src_clk) t_in = 1'b0;
        end
        @(negedge src_clk) t_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge src_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int e0, lat, base_in, base_out;
        joint_reset();

        // R1: quiet outputs out of reset
        check("R1 dst_evt after reset", int'(g_out), 0);
        check("R1 src_ovf after reset", int'(g_ovf), 0);
        check("R8 toggle ovf after reset", int'(t_ovf), 0);

        // R2/R3/R5: sweep gap x burst length in counter mode
        for (int gap = 0; gap <= 4; gap++) begin
            for (int len = 1; len <= 6; len++) begin
                g_burst(len, gap);
                drain();
                check($sformatf("R2 R3 count gap=%0d len=%0d", gap, len), g_seen, g_sent);
            end
        end
        check("R6 no overflow under legal traffic", int'(g_ovf), 0);

        // R4: isolated strobe latency at several phases
        for (int ph = 0; ph < 6; ph++) begin
            repeat (ph + 1) @(negedge src_clk);
            g_in = 1'b1;
            g_sent++;
            @(posedge src_clk);
            e0 = dedges;
            @(negedge src_clk) g_in = 1'b0;
            lat = -1;
            for (int k = 0; k < 20; k++) begin
                @(negedge dst_clk);
                if (g_out) begin
                    lat = dedges - e0;
                    break;
                end
            end
            check($sformatf("R4 latency in range ph=%0d (got %0d)", ph, lat),
                  int'(lat >= 2 && lat <= 5), 1);
            drain();
        end
        check("R2 count after latency runs", g_seen, g_sent);

        // R7/R8: toggle mode at legal spacing
        for (int gap = 2; gap <= 4; gap++) begin
            for (int len = 1; len <= 5; len++) begin
                t_burst(len, gap);
                drain();
                check($sformatf("R7 toggle count gap=%0d len=%0d", gap, len), t_seen, t_sent);
            end
        end
        check("R8 toggle ovf stays low", int'(t_ovf), 0);
        check("R2 counter-mode untouched by toggle traffic", g_seen, g_sent);

        // R6: freeze destination, push 10 strobes, only 7 accepted
        @(negedge dst_clk) dclk_en = 1'b0;
        base_out = g_seen;
        base_in  = g_sent;
        g_burst(10, 0);
        repeat (3) @(negedge src_clk);
        check("R6 overflow flag set", int'(g_ovf), 1);
        dclk_en = 1'b1;
        drain();
        check("R6 refused strobes never emerge", g_seen - base_out, 7);
        check("R6 sent count in test", g_sent - base_in, 10);
        repeat (10) @(negedge src_clk);
        check("R6 overflow flag sticky", int'(g_ovf), 1);

        // R1/R6: reset clears the flag and counting resumes cleanly
        joint_reset();
        check("R6 flag cleared by reset", int'(g_ovf), 0);
        check("R1 dst_evt quiet after second reset", int'(g_out), 0);
        base_out = g_seen;
        g_burst(5, 0);
        drain();
        check("R2 count after reset", g_seen - base_out, 5);

        finish_run();
    end
endmodule